// File: doc/BRIEF.md
# Reference and Loop Divider with Test Port Routing

This block sits at the front of a frequency synthesiser loop. It divides the crystal-rate clock by one of three reference ratios to form the reference pulse train. It divides a VCO-rate strobe by a programmable 15-bit ratio to form the loop feedback train. It then decides which signals reach the phase detector and how the two bidirectional port pins are driven.

The crystal oscillator is the block clock, so the reference divider advances on every edge. The VCO path arrives as a single-cycle strobe, `vco_tick`, and the loop divider advances only on that strobe.

Each divided output is high for the lower half of its count and low for the upper half. The falling edge therefore marks terminal count. Both the ratio code and the loop ratio are sampled only at terminal count, so every output period is whole. A two-bit test selector can do one of three things: leave normal operation in place, show both divided signals on the port pins, or feed the phase detector from the port pins instead of the internal dividers.

Top module: `refdiv_test_router`

## Requirements
- R1: With `ref_sel_b`=0 the reference period is 80 clock cycles, whatever `ref_sel_a` is.
- R2: With `ref_sel_a`=0 and `ref_sel_b`=1 the reference period is 128 clock cycles.
- R3: With `ref_sel_a`=1 and `ref_sel_b`=1 the reference period is 64 clock cycles.
- R4: With `div_n` of 256 or more and a strobe on every cycle, the feedback period (`pd_cy` in normal mode) is `div_n` strobes.
- R5: A `div_n` below 256 divides by 256.
- R6: A new ratio applied in mid-period does not shorten the running period. The new ratio first applies to the period that begins after the next falling edge.
- R7: Each divided output is high for floor(R/2) counts and low for the rest of its R counts. The falling edge marks terminal count.
- R8: With `test_sel`=2'b10 (bit 1 is the expose/external bit, bit 0 the pump-off bit), `port_pull[0]` is the inverse of `pd_ref` and `port_pull[1]` is the inverse of `pd_cy`. A pull of 1 drives the pin low.
- R9: With `test_sel`=2'b11, `pd_ref` follows `port_in[0]` and `pd_cy` follows `port_in[1]`, and both pulls are released (0).
- R10: With `test_sel[1]`=0, `port_pull` equals `port_ctl`, the phase detector sees the internal dividers, and `port_in` has no effect.
- R11: While `rst_n` is low, `pd_ref` and `pd_cy` are 0 in normal mode.
- R12: The loop divider advances only on cycles with `vco_tick`=1, so a strobe on every second cycle doubles the feedback period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vco_tick | input | 1 | One strobe per VCO-path period |
| ref_sel_a | input | 1 | Reference ratio code, bit A |
| ref_sel_b | input | 1 | Reference ratio code, bit B |
| div_n | input | 15 | Loop divider ratio |
| test_sel | input | 2 | Test selector: [1] expose/external, [0] pump-off |
| port_in | input | 2 | Pin levels read from port 0 and port 1 |
| port_ctl | input | 2 | Normal-mode pull enables for port 0 and port 1 |
| pd_ref | output | 1 | Reference signal to the phase detector |
| pd_cy | output | 1 | Feedback signal to the phase detector |
| port_pull | output | 2 | Open-collector pull-down enables for port 0 and port 1 |

## Verification
The hardest case to reach from the ports is a ratio change that lands inside a running period. To show that the change waits for terminal count, the bench must know where the counter is without reading it. The stimulus first waits for a falling edge of `pd_ref`, which fixes the counter phase. It then lets a known number of cycles pass before changing the code. The time to the next falling edge must equal the old ratio minus that offset, and the period after it must equal the new ratio.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    // Test selector: bit 1 expose/external, bit 0 pump-off (routing-neutral here)
    typedef enum logic [1:0] {
        TM_NORMAL   = 2'b00,
        TM_PUMP_OFF = 2'b01,
        TM_EXPOSE   = 2'b10,
        TM_EXTERNAL = 2'b11
    } test_mode_e;

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int W         = 8,
    parameter int MIN_RATIO = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] ratio_i,
    output logic         out_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] half;
    } div_state_t;

    div_state_t cur_q, nxt_d;

    // Down-counter; ratio sampled only at terminal count (cnt == 0)
    always_comb begin
        nxt_d = cur_q;
        if (en_i) begin
            if (cur_q.cnt == '0) begin
                nxt_d.cnt  = ratio_i - 1'b1;
                nxt_d.half = ratio_i >> 1;
            end else begin
                nxt_d.cnt = cur_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // High for the lowest half of the count; falls on reload
    assign out_o = (cur_q.cnt < cur_q.half);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cur_q.cnt));

    p_fall_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_o) |-> ($past(en_i) && ($past(cur_q.cnt) == '0)));

    p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.half != '0) |-> (int'(cur_q.half) >= MIN_RATIO / 2));

endmodule

// File: rtl/ratio_select.sv
module ratio_select #(
    parameter int REF_W      = 9,
    parameter int N_W        = 15,
    parameter int N_MIN      = 256,
    parameter int RATIO_WIDE = 80,
    parameter int RATIO_SLOW = 128,
    parameter int RATIO_FAST = 64
) (
    input  logic             sel_a_i,
    input  logic             sel_b_i,
    input  logic [N_W-1:0]   n_i,
    output logic [REF_W-1:0] ref_ratio_o,
    output logic [N_W-1:0]   main_ratio_o
);

    always_comb begin
        if (!sel_b_i)     ref_ratio_o = REF_W'(RATIO_WIDE);
        else if (sel_a_i) ref_ratio_o = REF_W'(RATIO_FAST);
        else              ref_ratio_o = REF_W'(RATIO_SLOW);
    end

    assign main_ratio_o = (n_i < N_W'(N_MIN)) ? N_W'(N_MIN) : n_i;

endmodule

// File: rtl/test_router.sv
module test_router
    import refdiv_pkg::*;
(
    input  test_mode_e  mode_i,
    input  logic        int_ref_i,
    input  logic        int_cy_i,
    input  logic [1:0]  ext_i,
    input  logic [1:0]  ctl_i,
    output logic        pd_ref_o,
    output logic        pd_cy_o,
    output logic [1:0]  pull_o
);

    always_comb begin
        pd_ref_o = int_ref_i;
        pd_cy_o  = int_cy_i;
        pull_o   = ctl_i;
        unique case (mode_i)
            TM_EXPOSE: begin
                pull_o = {~int_cy_i, ~int_ref_i};
            end
            TM_EXTERNAL: begin
                pd_ref_o = ext_i[0];
                pd_cy_o  = ext_i[1];
                pull_o   = 2'b00;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/refdiv_test_router.sv
module refdiv_test_router
    import refdiv_pkg::*;
#(
    parameter int N_W        = 15,
    parameter int N_MIN      = 256,
    parameter int RATIO_WIDE = 80,
    parameter int RATIO_SLOW = 128,
    parameter int RATIO_FAST = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_tick,
    input  logic           ref_sel_a,
    input  logic           ref_sel_b,
    input  logic [14:0]    div_n,
    input  logic [1:0]     test_sel,
    input  logic [1:0]     port_in,
    input  logic [1:0]     port_ctl,
    output logic           pd_ref,
    output logic           pd_cy,
    output logic [1:0]     port_pull
);

    localparam int REF_W    = $clog2(RATIO_WIDE + RATIO_SLOW + RATIO_FAST + 1);
    localparam int REF_MIN0 = (RATIO_WIDE < RATIO_SLOW) ? RATIO_WIDE : RATIO_SLOW;
    localparam int REF_MIN  = (REF_MIN0 < RATIO_FAST) ? REF_MIN0 : RATIO_FAST;

    logic [REF_W-1:0] ref_ratio;
    logic [N_W-1:0]   main_ratio;
    logic             int_ref, int_cy;
    test_mode_e       mode;

    assign mode = test_mode_e'(test_sel);

    ratio_select #(
        .REF_W(REF_W), .N_W(N_W), .N_MIN(N_MIN),
        .RATIO_WIDE(RATIO_WIDE), .RATIO_SLOW(RATIO_SLOW), .RATIO_FAST(RATIO_FAST)
    ) u_sel (
        .sel_a_i(ref_sel_a), .sel_b_i(ref_sel_b), .n_i(div_n),
        .ref_ratio_o(ref_ratio), .main_ratio_o(main_ratio)
    );

    tick_divider #(.W(REF_W), .MIN_RATIO(REF_MIN)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .en_i(1'b1), .ratio_i(ref_ratio), .out_o(int_ref)
    );

    tick_divider #(.W(N_W), .MIN_RATIO(N_MIN)) u_main_div (
        .clk(clk), .rst_n(rst_n), .en_i(vco_tick), .ratio_i(main_ratio), .out_o(int_cy)
    );

    test_router u_route (
        .mode_i(mode), .int_ref_i(int_ref), .int_cy_i(int_cy),
        .ext_i(port_in), .ctl_i(port_ctl),
        .pd_ref_o(pd_ref), .pd_cy_o(pd_cy), .pull_o(port_pull)
    );

    p_expose_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_sel == 2'b10) |-> (port_pull == {~int_cy, ~int_ref}));

    p_external_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_sel == 2'b11) |-> ((port_pull == 2'b00) && (pd_ref == port_in[0]) && (pd_cy == port_in[1])));

    p_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_sel[1]) |-> ((port_pull == port_ctl) && (pd_ref == int_ref) && (pd_cy == int_cy)));

endmodule

// File: tb/refdiv_test_router_test.sv
module refdiv_test_router_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        vco_tick;
    logic        ref_sel_a, ref_sel_b;
    logic [14:0] div_n;
    logic [1:0]  test_sel, port_in, port_ctl;
    logic        pd_ref, pd_cy;
    logic [1:0]  port_pull;
    logic        vco_half = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    refdiv_test_router uut (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick),
        .ref_sel_a(ref_sel_a), .ref_sel_b(ref_sel_b), .div_n(div_n),
        .test_sel(test_sel), .port_in(port_in), .port_ctl(port_ctl),
        .pd_ref(pd_ref), .pd_cy(pd_cy), .port_pull(port_pull)
    );

    // Table entries: {sel_a, sel_b, expected period}
    localparam logic [9:0] REF_TBL [4] = '{
        {1'b0, 1'b0, 8'd80},
        {1'b1, 1'b0, 8'd80},
        {1'b0, 1'b1, 8'd128},
        {1'b1, 1'b1, 8'd64}
    };

    initial begin
        vco_tick = 1'b0;
        forever begin
            @(negedge clk);
            vco_tick = vco_half ? ~vco_tick : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count negedges until the next falling edge of the chosen output
    task automatic count_to_fall(input bit which, output int n, output int hi);
        logic prev, cur;
        n = 0; hi = 0;
        prev = which ? pd_cy : pd_ref;
        for (int k = 0; k < 100000; k++) begin
            @(negedge clk);
            cur = which ? pd_cy : pd_ref;
            n++;
            if (cur) hi++;
            if (prev && !cur) return;
            prev = cur;
        end
        n = -1;
    endtask

    task automatic settle(input bit which);
        int n, h;
        for (int k = 0; k < 3; k++) count_to_fall(which, n, h);
    endtask

    initial begin
        int per, hi, exp;
        int bad;
        bit saw0, saw1;
        rst_n = 1'b0; ref_sel_a = 1'b0; ref_sel_b = 1'b0; div_n = 15'd300;
        test_sel = 2'b00; port_in = 2'b00; port_ctl = 2'b10;
        repeat (3) @(negedge clk);
        // R11 reset state; R10 pull follows control
        chk(pd_ref == 1'b0 && pd_cy == 1'b0, "R11 reset outputs", {pd_cy, pd_ref}, 0);
        chk(port_pull == 2'b10, "R10 pull in reset", port_pull, 2);
        rst_n = 1'b1;

        // Reference ratio table: R1 R2 R3 with R7 duty
        for (int i = 0; i < 4; i++) begin
            ref_sel_a = REF_TBL[i][9];
            ref_sel_b = REF_TBL[i][8];
            exp = int'(REF_TBL[i][7:0]);
            settle(1'b0);
            count_to_fall(1'b0, per, hi);
            chk(per == exp, exp == 80 ? "R1 ref period" : (exp == 128 ? "R2 ref period" : "R3 ref period"), per, exp);
            chk(hi == exp / 2, "R7 ref high time", hi, exp / 2);
        end

        // R6 mid-period change from 80 to 64
        ref_sel_a = 1'b0; ref_sel_b = 1'b0;
        settle(1'b0);
        repeat (5) @(negedge clk);
        ref_sel_a = 1'b1; ref_sel_b = 1'b1;
        count_to_fall(1'b0, per, hi);
        chk(per == 75, "R6 running period kept", per, 75);
        count_to_fall(1'b0, per, hi);
        chk(per == 64, "R6 new period", per, 64);

        // R4 loop divider
        div_n = 15'd300;
        settle(1'b1);
        count_to_fall(1'b1, per, hi);
        chk(per == 300, "R4 loop period", per, 300);
        chk(hi == 150, "R7 loop high time", hi, 150);

        // R5 clamp
        div_n = 15'd10;
        settle(1'b1);
        count_to_fall(1'b1, per, hi);
        chk(per == 256, "R5 clamp period", per, 256);

        // R12 half-rate strobe
        div_n = 15'd1000; vco_half = 1'b1;
        settle(1'b1);
        count_to_fall(1'b1, per, hi);
        chk(per == 2000, "R12 strobe gating", per, 2000);
        vco_half = 1'b0;
        div_n = 15'd300;

        // R10: port_in ignored, pump-off mode keeps routing
        ref_sel_a = 1'b0; ref_sel_b = 1'b0;
        test_sel = 2'b01; port_in = 2'b11; port_ctl = 2'b01;
        settle(1'b0);
        count_to_fall(1'b0, per, hi);
        chk(per == 80, "R10 port_in ignored", per, 80);
        chk(port_pull == 2'b01, "R10 pull follows control", port_pull, 1);

        // R8 expose mode
        test_sel = 2'b10; bad = 0; saw0 = 1'b0; saw1 = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (port_pull[0] != ~pd_ref || port_pull[1] != ~pd_cy) bad++;
            if (port_pull[0]) saw1 = 1'b1; else saw0 = 1'b1;
        end
        chk(bad == 0, "R8 pins mirror dividers", bad, 0);
        chk(saw0 && saw1, "R8 port 0 toggles", {saw1, saw0}, 3);

        // R9 external mode
        test_sel = 2'b11;
        for (int v = 0; v < 4; v++) begin
            port_in = 2'(v);
            @(negedge clk);
            chk({pd_cy, pd_ref} == 2'(v), "R9 external inputs", {pd_cy, pd_ref}, v);
        end
        chk(port_pull == 2'b00, "R9 pulls released", port_pull, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule